// File: doc/BRIEF.md
# Flag Threshold Register Window

This block keeps the two thresholds that a FIFO uses for its almost-empty flag (the value n) and its almost-full flag (the value m). Each threshold is held as a low byte and a high part, so there are four small registers. All four are reached through one circular window over the FIFO's own 9-bit data ports. A dual-role pin is sampled while reset is held. If it is low in reset, the pin becomes a load strobe and the window is open to access. If it is high in reset, the pin is a second write enable and the window cannot be reached.

The window has one position that write accesses and readback accesses share. Each load write stores the data input into the register at that position, and each readback copies that register onto the readback word. Either access moves the position on by one. The order is n low, n high, m low, m high, and after m high the position wraps to n low. Releasing the load strobe does not reset the position. Writes are taken on the write clock and readbacks on the read clock. The block also decodes the normal FIFO write and read strobes, and keeps FIFO reads out of the way while the window is being read.

Top module: `offs_window_seq`

## Requirements
- R1: Mode is taken from `wr_en2_ld` while `rst_n` is low. Low selects load mode and high selects dual-enable mode. The mode does not change until the next reset.
- R2: After reset, n and m are both 7. Readback returns 007h, 000h, 007h, 000h, in that order.
- R3: In load mode, a write-clock edge with `wr_en2_ld`=0 and `wr_en1_n`=0 stores `din` into the register at the current position. The positions run n-low, n-high, m-low, m-high. `empty_off`={n-high,n-low} and `full_off`={m-high,m-low}.
- R4: The fifth consecutive load write wraps to the n-low register.
- R5: Raising `wr_en2_ld` between load writes keeps the position. The next access goes to the following register.
- R6: In load mode, a read-clock edge with `wr_en2_ld`=0 and both read enables low loads the register at the shared position into `rd_word` and advances the position. At all other edges `rd_word` holds its value.
- R7: `fifo_we` is 1 exactly when `wr_en1_n`=0 and `wr_en2_ld`=1. In load mode, `wr_en2_ld`=0 with `wr_en1_n`=1 changes neither the registers nor the position.
- R8: Each low register keeps min(AW,8) bits and each high register keeps AW-8 bits, where AW=log2(DEPTH). The high registers keep no bits when DEPTH ≤ 256. Bits that are not kept read back as 0, and `rd_word` bit 8 is always 0.
- R9: A load write and a readback in the same cycle perform only the write. `rd_word` and the read-side position stay unchanged.
- R10: `fifo_re` is 1 when both read enables are low, except in load mode with `wr_en2_ld`=0, where it is 0.
- R11: In dual-enable mode, `wr_en2_ld`=0 never reaches the registers. The thresholds stay at their reset values and `rd_word` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both clocks |
| din | input | 9 | FIFO data input, also the load data |
| wr_en1_n | input | 1 | Active-low write enable |
| wr_en2_ld | input | 1 | Dual-role pin: load strobe (active low) or second write enable (active high) |
| rd_en1_n | input | 1 | Active-low read enable 1 |
| rd_en2_n | input | 1 | Active-low read enable 2 |
| fifo_we | output | 1 | Decoded FIFO data write |
| fifo_re | output | 1 | Decoded FIFO data read |
| empty_off | output | AW | Almost-empty threshold n |
| full_off | output | AW | Almost-full threshold m |
| rd_word | output | 9 | Readback of the selected threshold register |

## Verification
The assertions assume that window accesses on the write side and the read side never overlap in time. The shared position combines a write-clock counter with a read-clock counter, so each side must see the other side quiet. The stimulus meets this by running both clocks from one source and by opening at most one access per cycle. The only exception is the single deliberate collision cycle used to check write priority. The assertions also assume that the dual-role pin is held steady for the whole reset pulse, and every reset the bench applies keeps it steady.

// File: rtl/offs_pkg.sv
package offs_pkg;
    localparam int WORD_W = 9;
    localparam int REG_W  = 8;
    localparam int SLOTS  = 4;
    localparam int PTR_W  = $clog2(SLOTS);

    typedef logic [SLOTS-1:0][REG_W-1:0] win_t;

    typedef struct packed {
        logic             load_mode;
        logic [PTR_W-1:0] wr_cnt;
        win_t             win;
    } wr_state_t;

    typedef struct packed {
        logic [PTR_W-1:0]  rd_cnt;
        logic [WORD_W-1:0] word;
    } rd_state_t;
endpackage

// File: rtl/offs_wr_bank.sv
module offs_wr_bank
    import offs_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    din,
    input  logic                 wen1_n,
    input  logic                 ld_pin,
    input  logic [PTR_W-1:0]     rd_cnt,
    output logic                 load_mode,
    output logic                 wr_acc,
    output logic [PTR_W-1:0]     wr_cnt,
    output win_t                 win
);
    localparam int LSBW = (AW < REG_W) ? AW : REG_W;
    localparam int MSBW = (AW > REG_W) ? AW - REG_W : 0;
    localparam logic [REG_W-1:0] LSB_MASK = REG_W'((1 << LSBW) - 1);
    localparam logic [REG_W-1:0] MSB_MASK = REG_W'((1 << MSBW) - 1);
    localparam logic [REG_W-1:0] LSB_INIT = REG_W'(7) & LSB_MASK;

    wr_state_t        st_q, st_d;
    logic [PTR_W-1:0] slot;

    always_comb begin
        st_d   = st_q;
        slot   = st_q.wr_cnt + rd_cnt;
        wr_acc = st_q.load_mode && !ld_pin && !wen1_n;
        if (!rst_n) begin
            st_d.load_mode = !ld_pin;
            st_d.wr_cnt    = '0;
            st_d.win       = {REG_W'(0), LSB_INIT, REG_W'(0), LSB_INIT};
            wr_acc         = 1'b0;
        end else if (wr_acc) begin
            st_d.win[slot] = din[REG_W-1:0] & (slot[0] ? MSB_MASK : LSB_MASK);
            st_d.wr_cnt    = st_q.wr_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign load_mode = st_q.load_mode;
    assign wr_cnt    = st_q.wr_cnt;
    assign win       = st_q.win;

    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(load_mode));
    a_r3_nlow_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && slot == 2'd0) |=> win[0] == ($past(din[REG_W-1:0]) & LSB_MASK));
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_acc) |=> ($stable(win) && $stable(wr_cnt)));
endmodule

// File: rtl/offs_rd_port.sv
module offs_rd_port
    import offs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_mode,
    input  logic              ld_pin,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              wen1_n,
    input  logic [PTR_W-1:0]  wr_cnt,
    input  win_t              win,
    output logic              rd_acc,
    output logic [WORD_W-1:0] rd_word
);
    rd_state_t        st_q, st_d;
    logic [PTR_W-1:0] slot;

    always_comb begin
        st_d   = st_q;
        slot   = wr_cnt + st_q.rd_cnt;
        rd_acc = load_mode && !ld_pin && !ren1_n && !ren2_n && wen1_n;
        if (!rst_n) begin
            st_d   = '0;
            rd_acc = 1'b0;
        end else if (rd_acc) begin
            st_d.word   = {{(WORD_W-REG_W){1'b0}}, win[slot]};
            st_d.rd_cnt = st_q.rd_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_word = st_q.word;

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ld_pin && !wen1_n) |=> ($stable(rd_word) && $stable(st_q.rd_cnt)));
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rd_acc) |=> $stable(rd_word));
endmodule

// File: rtl/offs_window_seq.sv
module offs_window_seq
    import offs_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    output logic              fifo_we,
    output logic              fifo_re,
    output logic [AW-1:0]     empty_off,
    output logic [AW-1:0]     full_off,
    output logic [WORD_W-1:0] rd_word
);
    logic             load_mode, wr_acc, rd_acc;
    logic [PTR_W-1:0] wr_cnt, rd_cnt_w;
    win_t             win;

    offs_wr_bank #(.AW(AW)) wr_i (
        .clk(wclk), .rst_n(rst_n), .din(din), .wen1_n(wr_en1_n),
        .ld_pin(wr_en2_ld), .rd_cnt(rd_cnt_w), .load_mode(load_mode),
        .wr_acc(wr_acc), .wr_cnt(wr_cnt), .win(win)
    );

    offs_rd_port rd_i (
        .clk(rclk), .rst_n(rst_n), .load_mode(load_mode), .ld_pin(wr_en2_ld),
        .ren1_n(rd_en1_n), .ren2_n(rd_en2_n), .wen1_n(wr_en1_n),
        .wr_cnt(wr_cnt), .win(win), .rd_acc(rd_acc), .rd_word(rd_word)
    );

    assign rd_cnt_w = rd_i.st_q.rd_cnt;

    generate
        if (AW > REG_W) begin : g_wide
            assign empty_off = {win[1][AW-REG_W-1:0], win[0]};
            assign full_off  = {win[3][AW-REG_W-1:0], win[2]};
        end else begin : g_narrow
            assign empty_off = win[0][AW-1:0];
            assign full_off  = win[2][AW-1:0];
        end
    endgenerate

    assign fifo_we = rst_n && !wr_en1_n && wr_en2_ld;
    assign fifo_re = rst_n && !rd_en1_n && !rd_en2_n && !(load_mode && !wr_en2_ld);

    a_r7_we_excl: assert property (@(posedge wclk) disable iff (!rst_n)
        !(fifo_we && wr_acc));
    a_r10_re_excl: assert property (@(posedge rclk) disable iff (!rst_n)
        !(fifo_re && rd_acc));
endmodule

// File: tb/offs_window_seq_tb_top.sv
module offs_window_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] din = '0;
    logic       wr_en1_n = 1'b1, wr_en2_ld = 1'b0;
    logic       rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic       fifo_we, fifo_re;
    logic [9:0] empty_off, full_off;
    logic [8:0] rd_word;
    int         total = 0, bad = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    offs_window_seq #(.DEPTH(1024)) dut_i (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .din(din),
        .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
        .fifo_we(fifo_we), .fifo_re(fifo_re),
        .empty_off(empty_off), .full_off(full_off), .rd_word(rd_word)
    );

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {1'b0, rd_word}, {1'b0, e});
        end
    end

    task automatic idle();
        wr_en1_n = 1'b1; wr_en2_ld = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0; wr_en2_ld = pin; wr_en1_n = 1'b1;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        idle();
        tick();
    endtask

    task automatic ld_write(input logic [8:0] d);
        wr_en2_ld = 1'b0; wr_en1_n = 1'b0; din = d;
        tick();
        idle();
    endtask

    task automatic ld_read(input logic [8:0] e, input string tag);
        wr_en2_ld = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        @(posedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        chk("R2 n reset", empty_off, 10'h007);
        chk("R2 m reset", full_off, 10'h007);
        chk("R2 rd_word reset", {1'b0, rd_word}, 10'h000);
        ld_read(9'h007, "R2 R6 rb n-low");
        ld_read(9'h000, "R2 R6 rb n-high");
        ld_read(9'h007, "R2 R6 rb m-low");
        ld_read(9'h000, "R2 R6 rb m-high");
        // R3 / R8: order and bit masking
        ld_write(9'h1AB); ld_write(9'h1FF); ld_write(9'h055); ld_write(9'h002);
        chk("R3 R8 n assembled", empty_off, 10'h3AB);
        chk("R3 R8 m assembled", full_off, 10'h255);
        ld_read(9'h0AB, "R6 R8 rb n-low");
        ld_read(9'h003, "R6 R8 rb n-high");
        ld_read(9'h055, "R6 rb m-low");
        ld_read(9'h002, "R6 rb m-high");
        // R5: position kept while strobe released
        ld_write(9'h011);
        tick(); tick();
        ld_write(9'h001);
        chk("R5 n after gap", empty_off, 10'h111);
        // R4: wrap on fifth write
        ld_write(9'h033); ld_write(9'h000); ld_write(9'h044);
        chk("R4 wrap n", empty_off, 10'h144);
        chk("R4 m", full_off, 10'h033);
        // R7: decoded write and no-op
        wr_en2_ld = 1'b1; wr_en1_n = 1'b0; din = 9'h0EE; #1;
        chk("R7 fifo_we load mode", {9'b0, fifo_we}, 10'h001);
        tick();
        wr_en2_ld = 1'b0; wr_en1_n = 1'b1; #1;
        chk("R7 fifo_we off", {9'b0, fifo_we}, 10'h000);
        tick();
        idle();
        chk("R7 n unchanged", empty_off, 10'h144);
        chk("R7 m unchanged", full_off, 10'h033);
        // position is 1: no-op must not have advanced it
        ld_read(9'h001, "R7 R6 pointer not moved");
        // R10: FIFO read suppressed during window read
        wr_en2_ld = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0; #1;
        chk("R10 fifo_re blocked", {9'b0, fifo_re}, 10'h000);
        wr_en2_ld = 1'b1; #1;
        chk("R10 fifo_re normal", {9'b0, fifo_re}, 10'h001);
        idle(); #1;
        // R9: collision, write wins
        wr_en2_ld = 1'b0; wr_en1_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0; din = 9'h066;
        tick();
        idle();
        chk("R9 rd_word kept", {1'b0, rd_word}, 10'h001);
        chk("R9 m written", full_off, 10'h066);
        ld_read(9'h000, "R9 next slot m-high");
        tick();
        // R1 / R11: dual-enable mode
        do_reset(1'b1);
        wr_en2_ld = 1'b1; wr_en1_n = 1'b0; #1;
        chk("R1 fifo_we dual", {9'b0, fifo_we}, 10'h001);
        wr_en2_ld = 1'b0; din = 9'h0AA; #1;
        chk("R1 fifo_we dual off", {9'b0, fifo_we}, 10'h000);
        tick();
        rd_en1_n = 1'b0; rd_en2_n = 1'b0; wr_en1_n = 1'b1; #1;
        chk("R11 fifo_re dual", {9'b0, fifo_re}, 10'h001);
        tick();
        idle();
        chk("R11 n kept", empty_off, 10'h007);
        chk("R11 m kept", full_off, 10'h007);
        chk("R11 rd_word kept", {1'b0, rd_word}, 10'h000);
        tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule